// File: doc/BRIEF.md
# Destructive-Read Decimal Register Store with Unit-Step Adder

This block keeps a small bank of signed decimal registers. Each register is a row of BCD digits plus one sign digit on top. The sign is taken from the parity of the sign digit: an even value means positive and an odd value means negative. Reading a register hands back its contents and leaves it at zero. A variant of the read also writes the value into a second register in the same cycle, so the value survives.

Addition works by counting rather than by a carry-lookahead pass. On each cycle, every nonzero digit of the addend register counts down by one and the matching accumulator digit counts up by one. An accumulator digit that wraps from 9 to 0 leaves a pending carry for the digit above it. Once the addend is exhausted, the pending carries move up one position per cycle until none remain. At the end the addend register is zero and the accumulator holds the sum.

Commands arrive on a single valid-qualified port. Read data and the status pulses come back one cycle after a command is accepted.

Top module: `dec_store_acc`

## Requirements
- R1: After reset every register reads as zero, and `busy`, `done`, `err`, `ovf` and `rd_valid` are all low.
- R2: A read (op 0) of register `cmd_src` returns its word on `rd_data` with `rd_valid` high one cycle after acceptance, and the register then holds zero.
- R3: A read-with-copy (op 1) returns the word of `cmd_src`, clears `cmd_src` and writes the word into `cmd_dst`. When `cmd_dst` equals `cmd_src`, the register keeps its value.
- R4: An add (op 3, addend `cmd_src`, accumulator `cmd_dst`) leaves the decimal sum in the accumulator digits, keeps the accumulator's sign digit, and leaves the whole addend register (sign included) at zero.
- R5: Carries ripple through any run of 9 digits (for example 99 9999 + 1 gives 100 0000).
- R6: The stepping phase lasts at most 9 cycles. `busy` is high from the cycle after an add is accepted until `done`. `done` is a one-cycle pulse that comes m+k+2 clock edges after acceptance, where m is the largest addend digit and k is the ripple length. With m=3 and k=0 it comes 5 edges after acceptance.
- R7: A carry out of the most significant digit sets `ovf`, which stays set until reset. The wrapped digits stay in the accumulator.
- R8: An add whose two sign digits differ in bit 0, or whose `cmd_src` equals `cmd_dst`, is rejected. `err` pulses high for one cycle, no add starts, and neither register changes. Two odd signs are accepted, and the result keeps the accumulator's sign digit.
- R9: Commands presented while `busy` is high are ignored. They produce no read data and change no register.
- R10: In a register word, digit i occupies bits [4i+3:4i] and the sign digit occupies the top four bits. A write (op 2) stores `wr_data` into `cmd_dst` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command strobe, accepted when `busy` is low |
| cmd_op | input | 2 | 0 read, 1 read-with-copy, 2 write, 3 add |
| cmd_src | input | AW | Source register (addend for add) |
| cmd_dst | input | AW | Destination register (accumulator for add) |
| wr_data | input | 4*(NUM_DIGITS+1) | Word for write commands |
| rd_data | output | 4*(NUM_DIGITS+1) | Word returned by the last read |
| rd_valid | output | 1 | One-cycle pulse with new read data |
| busy | output | 1 | Add in progress |
| done | output | 1 | One-cycle pulse at the end of an add |
| err | output | 1 | One-cycle pulse for a rejected add |
| ovf | output | 1 | Sticky overflow out of the top digit |

## Verification
The bench builds the block with eight digits and four registers. With eight digits, a full run of nines is short enough that overflow out of the top digit and complete carry ripples can be reached with hand-sized BCD literals. Four registers allow a copy target, an untouched bystander and an operand pair at the same time. Exact `done` latency is checked on an add with no carries, and commands are injected during a long ripple to show that the busy window rejects them.

// File: rtl/dacc_pkg.sv
package dacc_pkg;
  typedef enum logic [1:0] {
    OP_READ      = 2'd0,
    OP_READ_COPY = 2'd1,
    OP_WRITE     = 2'd2,
    OP_ADD       = 2'd3
  } dacc_op_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_STEP  = 2'd1,
    PH_CARRY = 2'd2
  } dacc_phase_e;

  localparam int DIGIT_W = 4;

  // odd sign digit means negative
  function automatic logic sign_is_neg(input logic [DIGIT_W-1:0] s);
    return s[0];
  endfunction
endpackage

// File: rtl/dacc_lanes.sv
module dacc_lanes #(
  parameter int NUM_DIGITS = 40
) (
  input  logic [NUM_DIGITS*4-1:0] acc_i,
  input  logic [NUM_DIGITS*4-1:0] addend_i,
  input  logic [NUM_DIGITS-1:0]   pend_i,
  input  logic                    step_en,
  input  logic                    carry_en,
  output logic [NUM_DIGITS*4-1:0] acc_o,
  output logic [NUM_DIGITS*4-1:0] addend_o,
  output logic [NUM_DIGITS-1:0]   pend_o,
  output logic                    carry_out
);
  logic [NUM_DIGITS-1:0] wrap;
  logic [NUM_DIGITS-1:0] keep;

  // stepping keeps earlier pending carries; the carry phase consumes them
  assign keep = step_en ? pend_i : '0;

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_lane
    logic [3:0] a_dig;
    logic [3:0] c_dig;
    logic       dec;
    logic       inc;
    assign a_dig = addend_i[g*4 +: 4];
    assign c_dig = acc_i[g*4 +: 4];
    assign dec   = step_en && (a_dig != 4'd0);
    assign inc   = dec || (carry_en && pend_i[g]);
    assign wrap[g] = inc && (c_dig == 4'd9);
    assign acc_o[g*4 +: 4]    = !inc ? c_dig : (wrap[g] ? 4'd0 : c_dig + 4'd1);
    assign addend_o[g*4 +: 4] = dec ? a_dig - 4'd1 : a_dig;
    if (g == 0) begin : g_low
      assign pend_o[g] = keep[g];
    end else begin : g_up
      assign pend_o[g] = keep[g] | wrap[g-1];
    end
  end

  assign carry_out = wrap[NUM_DIGITS-1];
endmodule

// File: rtl/dacc_ctrl.sv
module dacc_ctrl
  import dacc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic addend_zero,
  input  logic pend_zero,
  output logic step_en,
  output logic carry_en,
  output logic step_phase,
  output logic busy,
  output logic done
);
  dacc_phase_e state_q, state_d;
  logic        done_q, done_d;
  logic [3:0]  step_cnt_q, step_cnt_d;

  always_comb begin
    state_d    = state_q;
    done_d     = 1'b0;
    step_cnt_d = step_cnt_q;
    unique case (state_q)
      PH_IDLE: begin
        step_cnt_d = 4'd0;
        if (start) state_d = PH_STEP;
      end
      PH_STEP: begin
        if (addend_zero) state_d = PH_CARRY;
        else             step_cnt_d = step_cnt_q + 4'd1;
      end
      PH_CARRY: begin
        if (pend_zero) begin
          state_d = PH_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= PH_IDLE;
      done_q     <= 1'b0;
      step_cnt_q <= 4'd0;
    end else begin
      state_q    <= state_d;
      done_q     <= done_d;
      step_cnt_q <= step_cnt_d;
    end
  end

  assign step_phase = (state_q == PH_STEP);
  assign step_en    = step_phase && !addend_zero;
  assign carry_en   = (state_q == PH_CARRY);
  assign busy       = (state_q != PH_IDLE);
  assign done       = done_q;

  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    step_phase |-> (step_cnt_q <= 4'd9)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R6
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(busy)); // R6
endmodule

// File: rtl/dec_store_acc.sv
module dec_store_acc
  import dacc_pkg::*;
#(
  parameter  int NUM_REGS   = 4,
  parameter  int NUM_DIGITS = 40,
  localparam int AW     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int WORD_W = DIGIT_W * (NUM_DIGITS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [AW-1:0]     cmd_src,
  input  logic [AW-1:0]     cmd_dst,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              ovf
);
  localparam int MAG_W = DIGIT_W * NUM_DIGITS;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  logic [WORD_W-1:0]     bank_q [NUM_REGS];
  logic [WORD_W-1:0]     bank_d [NUM_REGS];
  logic [WORD_W-1:0]     rd_data_q, rd_data_d;
  logic                  rd_valid_q, rd_valid_d;
  logic                  err_q, err_d;
  logic                  ovf_q, ovf_d;
  logic [AW-1:0]         src_q, src_d, dst_q, dst_d;
  logic [NUM_DIGITS-1:0] pend_q, pend_d;

  logic                  start, accept;
  logic                  step_en, carry_en, step_phase;
  logic                  addend_zero, pend_zero;
  logic [MAG_W-1:0]      lane_acc, lane_add;
  logic [NUM_DIGITS-1:0] lane_pend;
  logic                  lane_cout;
  dacc_op_e              op;

  assign op          = dacc_op_e'(cmd_op);
  assign accept      = cmd_valid && !busy;
  assign addend_zero = (bank_q[src_q][MAG_W-1:0] == '0);
  assign pend_zero   = (pend_q == '0);

  dacc_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .start       (start),
    .addend_zero (addend_zero),
    .pend_zero   (pend_zero),
    .step_en     (step_en),
    .carry_en    (carry_en),
    .step_phase  (step_phase),
    .busy        (busy),
    .done        (done)
  );

  dacc_lanes #(.NUM_DIGITS(NUM_DIGITS)) u_lanes (
    .acc_i     (bank_q[dst_q][MAG_W-1:0]),
    .addend_i  (bank_q[src_q][MAG_W-1:0]),
    .pend_i    (pend_q),
    .step_en   (step_en),
    .carry_en  (carry_en),
    .acc_o     (lane_acc),
    .addend_o  (lane_add),
    .pend_o    (lane_pend),
    .carry_out (lane_cout)
  );

  always_comb begin
    bank_d     = bank_q;
    rd_data_d  = rd_data_q;
    rd_valid_d = 1'b0;
    err_d      = 1'b0;
    ovf_d      = ovf_q;
    src_d      = src_q;
    dst_d      = dst_q;
    pend_d     = pend_q;
    start      = 1'b0;
    if (accept) begin
      unique case (op)
        OP_READ: begin
          rd_data_d        = bank_q[cmd_src];
          rd_valid_d       = 1'b1;
          bank_d[cmd_src]  = '0;
        end
        OP_READ_COPY: begin
          rd_data_d        = bank_q[cmd_src];
          rd_valid_d       = 1'b1;
          bank_d[cmd_src]  = '0;
          bank_d[cmd_dst]  = bank_q[cmd_src];
        end
        OP_WRITE: begin
          bank_d[cmd_dst]  = wr_data;
        end
        OP_ADD: begin
          if ((cmd_src != cmd_dst) &&
              (sign_is_neg(bank_q[cmd_src][WORD_W-1 -: DIGIT_W]) ==
               sign_is_neg(bank_q[cmd_dst][WORD_W-1 -: DIGIT_W]))) begin
            start  = 1'b1;
            src_d  = cmd_src;
            dst_d  = cmd_dst;
            pend_d = '0;
          end else begin
            err_d  = 1'b1;
          end
        end
        default: ;
      endcase
    end
    if (step_en || carry_en) begin
      bank_d[dst_q][MAG_W-1:0] = lane_acc;
      bank_d[src_q][MAG_W-1:0] = lane_add;
      pend_d                   = lane_pend;
      if (lane_cout) ovf_d     = 1'b1;
    end
    if (step_phase && addend_zero) begin
      bank_d[src_q][WORD_W-1 -: DIGIT_W] = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      for (int i = 0; i < NUM_REGS; i++) bank_q[i] <= '0;
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
      err_q      <= 1'b0;
      ovf_q      <= 1'b0;
      src_q      <= '0;
      dst_q      <= '0;
      pend_q     <= '0;
    end else begin
      for (int i = 0; i < NUM_REGS; i++) bank_q[i] <= bank_d[i];
      rd_data_q  <= rd_data_d;
      rd_valid_q <= rd_valid_d;
      err_q      <= err_d;
      ovf_q      <= ovf_d;
      src_q      <= src_d;
      dst_q      <= dst_d;
      pend_q     <= pend_d;
    end
  end

  assign rd_data  = rd_data_q;
  assign rd_valid = rd_valid_q;
  assign err      = err_q;
  assign ovf      = ovf_q;

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_s_n)
    ovf_q |=> ovf_q); // R7
  AST_ADDEND_CLEARED: assert property (@(posedge clk) disable iff (!rst_s_n)
    done |-> (bank_q[src_q] == '0)); // R4
  AST_BUSY_NO_READ: assert property (@(posedge clk) disable iff (!rst_s_n)
    (busy && $past(busy)) |-> !rd_valid_q); // R9
  AST_ERR_NO_START: assert property (@(posedge clk) disable iff (!rst_s_n)
    err_q |-> !busy); // R8
endmodule

// File: tb/tb_dec_store_acc.sv
module tb_dec_store_acc;
  localparam int ND = 8;
  localparam int NR = 4;
  localparam int WW = 4 * (ND + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cmd_valid;
  logic [1:0]    cmd_op;
  logic [1:0]    cmd_src, cmd_dst;
  logic [WW-1:0] wr_data;
  logic [WW-1:0] rd_data;
  logic          rd_valid, busy, done, err, ovf;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk; // 125 MHz

  dec_store_acc #(.NUM_REGS(NR), .NUM_DIGITS(ND)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_src(cmd_src), .cmd_dst(cmd_dst), .wr_data(wr_data),
    .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy), .done(done),
    .err(err), .ovf(ovf)
  );

  task automatic check(input string req, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // reference sum: accumulator sign kept, digit-by-digit decimal add
  function automatic logic [WW:0] model_add(input logic [WW-1:0] acc, input logic [WW-1:0] ad);
    logic [WW-1:0] r;
    int c = 0;
    r = acc;
    for (int i = 0; i < ND; i++) begin
      int s;
      s = int'(acc[i*4 +: 4]) + int'(ad[i*4 +: 4]) + c;
      c = (s > 9) ? 1 : 0;
      r[i*4 +: 4] = 4'(s % 10);
    end
    return {c[0], r};
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'd0; cmd_src = '0; cmd_dst = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // drives at a falling edge, returns at the falling edge after acceptance
  task automatic issue(input logic [1:0] op, input logic [1:0] s, input logic [1:0] d, input logic [WW-1:0] w);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_src = s; cmd_dst = d; wr_data = w;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wr(input logic [1:0] d, input logic [WW-1:0] w);
    issue(2'd2, 2'd0, d, w);
  endtask

  task automatic rd(input logic [1:0] s, output logic [WW-1:0] v);
    issue(2'd0, s, 2'd0, '0);
    v = rd_data;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (!done && n < 200) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset();
    logic [WW-1:0] v;
    check("R1 busy", {35'd0, busy}, '0);
    check("R1 flags", {31'd0, done, err, ovf, rd_valid, busy}, '0);
    for (int i = 0; i < NR; i++) begin
      rd(2'(i), v);
      check("R1 reg zero", v, '0);
    end
  endtask

  task automatic t_write_read();
    logic [WW-1:0] v;
    wr(2'd1, 36'h3_1234_5678);
    issue(2'd0, 2'd1, 2'd0, '0);
    check("R2 rd_valid", {35'd0, rd_valid}, 36'd1);
    check("R10 R2 read word", rd_data, 36'h3_1234_5678);
    rd(2'd1, v);
    check("R2 cleared after read", v, '0);
  endtask

  task automatic t_copy();
    logic [WW-1:0] v;
    wr(2'd0, 36'h5_0000_9876);
    issue(2'd1, 2'd0, 2'd2, '0);
    check("R3 copy read data", rd_data, 36'h5_0000_9876);
    rd(2'd0, v);
    check("R3 source cleared", v, '0);
    rd(2'd2, v);
    check("R3 copy target", v, 36'h5_0000_9876);
    wr(2'd1, 36'h0_4444_0001);
    issue(2'd1, 2'd1, 2'd1, '0);
    check("R3 self copy data", rd_data, 36'h0_4444_0001);
    rd(2'd1, v);
    check("R3 self copy kept", v, 36'h0_4444_0001);
  endtask

  task automatic t_add_latency();
    logic [WW-1:0] v;
    int n;
    wr(2'd0, 36'h2_0000_1234);
    wr(2'd1, 36'h4_0000_0321);
    issue(2'd3, 2'd1, 2'd0, '0);
    check("R6 busy after accept", {35'd0, busy}, 36'd1);
    wait_done(n);
    check("R6 done latency", 36'(n), 36'd5);
    @(negedge clk);
    check("R6 done one cycle", {34'd0, done, busy}, '0);
    rd(2'd0, v);
    check("R4 sum sign kept", v, 36'h2_0000_1555);
    rd(2'd1, v);
    check("R4 addend zero", v, '0);
  endtask

  task automatic t_add_pair(input string req, input logic [WW-1:0] a, input logic [WW-1:0] b);
    logic [WW-1:0] v;
    logic [WW:0]   m;
    int n;
    m = model_add(a, b);
    wr(2'd2, a);
    wr(2'd3, b);
    issue(2'd3, 2'd3, 2'd2, '0);
    wait_done(n);
    check({req, " done seen"}, {35'd0, done}, 36'd1);
    rd(2'd2, v);
    check({req, " sum"}, v, m[WW-1:0]);
    rd(2'd3, v);
    check({req, " addend zero"}, v, '0);
  endtask

  task automatic t_reject();
    logic [WW-1:0] v;
    wr(2'd0, 36'h2_0000_0005);
    wr(2'd1, 36'h1_0000_0007);
    issue(2'd3, 2'd1, 2'd0, '0);
    check("R8 err on parity mismatch", {34'd0, err, busy}, 36'd2);
    @(negedge clk);
    check("R8 err pulse", {35'd0, err}, '0);
    issue(2'd3, 2'd0, 2'd0, '0);
    check("R8 err on same register", {34'd0, err, busy}, 36'd2);
    rd(2'd0, v);
    check("R8 acc unchanged", v, 36'h2_0000_0005);
    rd(2'd1, v);
    check("R8 addend unchanged", v, 36'h1_0000_0007);
  endtask

  task automatic t_busy_ignore();
    logic [WW-1:0] v;
    int n;
    wr(2'd3, 36'h0_0000_0042);
    wr(2'd2, 36'h0_0000_0017);
    wr(2'd0, 36'h0_0099_9999);
    wr(2'd1, 36'h0_0000_0001);
    issue(2'd3, 2'd1, 2'd0, '0);
    cmd_valid = 1'b1; cmd_op = 2'd2; cmd_dst = 2'd3; wr_data = 36'h0_0000_0777;
    @(negedge clk);
    cmd_op = 2'd0; cmd_src = 2'd2;
    @(negedge clk);
    check("R9 no read while busy", {34'd0, rd_valid, busy}, 36'd1);
    cmd_valid = 1'b0;
    wait_done(n);
    rd(2'd3, v);
    check("R9 write ignored", v, 36'h0_0000_0042);
    rd(2'd2, v);
    check("R9 read ignored", v, 36'h0_0000_0017);
    rd(2'd0, v);
    check("R5 long ripple", v, 36'h0_0100_0000);
  endtask

  task automatic t_overflow();
    logic [WW-1:0] v;
    int n;
    wr(2'd0, 36'h0_9999_9999);
    wr(2'd1, 36'h0_0000_0001);
    issue(2'd3, 2'd1, 2'd0, '0);
    wait_done(n);
    check("R7 ovf set", {35'd0, ovf}, 36'd1);
    rd(2'd0, v);
    check("R7 wrapped digits kept", v, '0);
    wr(2'd0, 36'h0_0000_0002);
    wr(2'd1, 36'h0_0000_0003);
    issue(2'd3, 2'd1, 2'd0, '0);
    wait_done(n);
    rd(2'd0, v);
    check("R7 later sum", v, 36'h0_0000_0005);
    check("R7 ovf sticky", {35'd0, ovf}, 36'd1);
    do_reset();
    check("R1 ovf cleared by reset", {35'd0, ovf}, '0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    t_reset();
    t_write_read();
    t_copy();
    t_add_latency();
    t_add_pair("R5", 36'h0_0099_9999, 36'h0_0000_0001);
    t_add_pair("R4 R8 negative pair", 36'h1_1875_4329, 36'h3_0468_7796);
    t_add_pair("R4 R10 mixed digits", 36'h6_0905_0909, 36'h8_0195_9191);
    t_reject();
    t_busy_ignore();
    t_overflow();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule